// File: doc/BRIEF.md
# DMA Completion Interrupt Router

The router collects per-channel completion pulses and a single error pulse from a DMA transfer engine. It turns them into interrupt requests for a processor. The engine itself lies outside this block.

A master interrupt line covers every channel through a status mask with one bit per channel. Any number of bits in that mask may be pending together. Three configurable interrupt lines can each be given one channel. While a channel is given to a configurable line, the master path hardware-masks it: its completions do not appear in the master status, and clearing its master bit does nothing. A separate error line reports engine errors.

A small register port handles the setup. Through it software reads status, clears individual bits, sets the line enables, chooses channel assignments, handles the error flag, and raises one-cycle software start requests toward the engine. Register writes take effect on the clock edge that samples them. Reads are combinational on the read address. Every interface is a plain control pin, so there is no back-pressure to manage.

Top module: `dma_irq_router`

## Requirements
- R1: After reset every status bit, configurable flag, enable, assignment, the error flag and all outputs are zero.
- R2: A completion pulse on a channel that no configurable line holds sets that channel's bit in the master status register (address 0, bit n = channel n) on the next clock edge. Bits from different pulses accumulate.
- R3: irq_master is high exactly when the master enable (address 1, bit 0) is set and at least one visible master status bit is set.
- R4: A channel held by a configurable line is hidden from the address-0 reading and from irq_master. Its completions do not set its master bit. Writing 1 to its bit at address 0 has no effect.
- R5: Writing 1 to bit n at address 0 clears the master bit of unheld channel n. A completion on that channel in the same cycle wins, and the bit stays set.
- R6: Configurable line k uses the assignment register at address 2+k: bit 7 = assignment valid, bits 2:0 = channel. A completion on the assigned channel sets flag k (address 5, bit k) on the next edge. irq_cfg[k] equals flag k AND enable bit k+1 at address 1. Writing 1 to bit k at address 5 clears the flag, but a same-cycle completion wins.
- R7: An error pulse sets the error flag (address 6, bit 0). irq_err equals that flag AND enable bit 4 at address 1. Writing 1 to bit 0 at address 6 clears the flag.
- R8: A write to address 7 drives sw_req with the written channel mask for exactly the one cycle after the write edge. At all other times sw_req is zero.
- R9: Clearing the valid bit of an assignment returns the channel to the master path. A master bit set before the assignment is visible again, and the channel's completions no longer set the configurable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_pulse | input | NUM_CH | One-cycle completion pulse per channel |
| err_pulse | input | 1 | One-cycle engine error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| irq_master | output | 1 | Master interrupt request |
| irq_cfg | output | NUM_CFG | Configurable interrupt requests |
| irq_err | output | 1 | Error interrupt request |
| sw_req | output | NUM_CH | One-cycle software start request per channel |

## Verification
The assertions check on every cycle that:
- an unheld completion lands in the master status;
- a held channel's raw master bit never rises;
- a clear write without a competing completion empties the bit;
- configurable and error flags follow their pulses;
- irq_master never rises without a visible bit;
- sw_req only follows a write to its address.

Only the bench scenarios show the read-side behaviour:
- the register encodings;
- which event wins when a set and a clear fall in the same cycle;
- the enable gating of each line;
- a bit pending before an assignment reappearing after the channel is released.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ASN0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ERR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_SWREQ = 3'd7;
endpackage

// File: rtl/dma_irq_slot.sv
module dma_irq_slot #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asn_we,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] done,
  output logic              asn_valid,
  output logic [CH_W-1:0]   asn_ch,
  output logic [NUM_CH-1:0] mask,
  output logic              hit,
  output logic              flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asn_valid <= 1'b0;
      asn_ch    <= '0;
    end else if (asn_we) begin
      asn_valid <= wdata[DATA_W-1];
      asn_ch    <= wdata[CH_W-1:0];
    end
  end

  always_comb begin
    mask = '0;
    if (asn_valid) mask[asn_ch] = 1'b1;
  end

  assign hit = |(done & mask);

  // a completion in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/dma_irq_master.sv
module dma_irq_master #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done,
  input  logic [NUM_CH-1:0] held,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_bits,
  output logic [NUM_CH-1:0] raw_status,
  output logic [NUM_CH-1:0] vis_status
);
  logic [NUM_CH-1:0] clr_eff;
  logic [NUM_CH-1:0] set_eff;

  assign clr_eff = clr_we ? (clr_bits & ~held) : '0;
  assign set_eff = done & ~held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_status <= '0;
    else        raw_status <= (raw_status & ~clr_eff) | set_eff;
  end

  assign vis_status = raw_status & ~held;
endmodule

// File: rtl/dma_irq_err.sv
module dma_irq_err (
  input  logic clk,
  input  logic rst_n,
  input  logic err_pulse,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (err_pulse) flag <= 1'b1;
    else if (clr)       flag <= 1'b0;
  end
endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_CFG = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  done_pulse,
  input  logic               err_pulse,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [2:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_master,
  output logic [NUM_CFG-1:0] irq_cfg,
  output logic               irq_err,
  output logic [NUM_CH-1:0]  sw_req
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int EN_W = NUM_CFG + 2;
  localparam int ERR_EN_BIT = NUM_CFG + 1;

  logic [EN_W-1:0]   en_q;
  logic [NUM_CH-1:0] slot_mask [NUM_CFG];
  logic [NUM_CH-1:0] mask_all;
  logic [NUM_CFG-1:0] cfg_flag, cfg_hit, asn_valid;
  logic [CH_W-1:0]   asn_ch [NUM_CFG];
  logic [NUM_CH-1:0] raw_status, vis_status;
  logic              err_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         en_q <= '0;
    else if (wr_en && wr_addr == A_EN)  en_q <= wr_data[EN_W-1:0];
  end

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_slot
    dma_irq_slot #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .asn_we    (wr_en && wr_addr == A_ASN0 + ADDR_W'(k)),
      .flag_clr  (wr_en && wr_addr == A_FLAG && wr_data[k]),
      .wdata     (wr_data),
      .done      (done_pulse),
      .asn_valid (asn_valid[k]),
      .asn_ch    (asn_ch[k]),
      .mask      (slot_mask[k]),
      .hit       (cfg_hit[k]),
      .flag      (cfg_flag[k])
    );
    assign irq_cfg[k] = cfg_flag[k] & en_q[k+1];
  end

  always_comb begin
    mask_all = '0;
    for (int k = 0; k < NUM_CFG; k++) mask_all = mask_all | slot_mask[k];
  end

  dma_irq_master #(.NUM_CH(NUM_CH)) u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done_pulse),
    .held       (mask_all),
    .clr_we     (wr_en && wr_addr == A_STAT),
    .clr_bits   (wr_data[NUM_CH-1:0]),
    .raw_status (raw_status),
    .vis_status (vis_status)
  );

  dma_irq_err u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_pulse (err_pulse),
    .clr       (wr_en && wr_addr == A_ERR && wr_data[0]),
    .flag      (err_flag)
  );

  assign irq_master = en_q[0] & (|vis_status);
  assign irq_err    = err_flag & en_q[ERR_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            sw_req <= '0;
    else if (wr_en && wr_addr == A_SWREQ)  sw_req <= wr_data[NUM_CH-1:0];
    else                                   sw_req <= '0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT:  rd_data[NUM_CH-1:0] = vis_status;
      A_EN:    rd_data[EN_W-1:0]   = en_q;
      A_FLAG:  rd_data[NUM_CFG-1:0] = cfg_flag;
      A_ERR:   rd_data[0]          = err_flag;
      default: begin
        for (int k = 0; k < NUM_CFG; k++) begin
          if (rd_addr == A_ASN0 + ADDR_W'(k)) begin
            rd_data[DATA_W-1] = asn_valid[k];
            rd_data[CH_W-1:0] = asn_ch[k];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/dma_irq_router_chk.sv
module dma_irq_router_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_CFG = 3,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_CH-1:0]  done_pulse,
  input logic               err_pulse,
  input logic               wr_en,
  input logic [2:0]         wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               irq_master,
  input logic [NUM_CH-1:0]  sw_req,
  input logic [NUM_CH-1:0]  mask_all,
  input logic [NUM_CH-1:0]  raw_status,
  input logic [NUM_CH-1:0]  vis_status,
  input logic [NUM_CFG-1:0] cfg_hit,
  input logic [NUM_CFG-1:0] cfg_flag,
  input logic               err_flag
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r2_unheld_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse[c] && !mask_all[c]) |=> (vis_status[c] || mask_all[c]));
    a_r4_held_raw_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_all[c] && !raw_status[c]) |=> !raw_status[c]);
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_STAT && wr_data[c] && !done_pulse[c]) |=> !vis_status[c]);
  end

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    a_r6_flag_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit[k] |=> cfg_flag[k]);
  end

  a_r3_master_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_master |-> (|vis_status));
  a_r7_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> err_flag);
  a_r8_swreq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_req) |-> $past(wr_en && wr_addr == A_SWREQ));
endmodule

bind dma_irq_router dma_irq_router_chk #(
  .NUM_CH(NUM_CH), .NUM_CFG(NUM_CFG), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_pulse (done_pulse),
  .err_pulse  (err_pulse),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .irq_master (irq_master),
  .sw_req     (sw_req),
  .mask_all   (mask_all),
  .raw_status (raw_status),
  .vis_status (vis_status),
  .cfg_hit    (cfg_hit),
  .cfg_flag   (cfg_flag),
  .err_flag   (err_flag)
);

// File: tb/test_dma_irq_router.sv
`timescale 1ns/1ps
module test_dma_irq_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] done_pulse = '0;
  logic       err_pulse = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_master, irq_err;
  logic [2:0] irq_cfg;
  logic [7:0] sw_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_irq_router i_dma_irq_router (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_master(irq_master), .irq_cfg(irq_cfg),
    .irq_err(irq_err), .sw_req(sw_req)
  );

  // {done mask, clear mask written to address 0, expected address-0 read}
  localparam logic [23:0] VEC [8] = '{
    24'h01_00_01, 24'h84_00_85, 24'h00_01_84, 24'h10_10_94,
    24'h00_FF_00, 24'hFF_00_FF, 24'h00_0F_F0, 24'h00_F0_00
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] d, input logic e, input logic we,
                     input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    done_pulse = d; err_pulse = e; wr_en = we; wr_addr = a; wr_data = v;
    @(negedge clk);
    done_pulse = '0; err_pulse = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    cyc(8'h00, 1'b0, 1'b1, a, v);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  logic [7:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, r); check("R1 status", r, 8'h00);
    rd(3'd1, r); check("R1 enables", r, 8'h00);
    rd(3'd2, r); check("R1 assign0", r, 8'h00);
    rd(3'd5, r); check("R1 flags", r, 8'h00);
    rd(3'd6, r); check("R1 err", r, 8'h00);
    check("R1 outputs", {irq_master, irq_err, irq_cfg}, 8'h00);
    check("R1 sw_req", sw_req, 8'h00);

    // R2 / R5 vector walk
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][23:16], 1'b0, |VEC[i][15:8], 3'd0, VEC[i][15:8]);
      rd(3'd0, r); check($sformatf("R2/R5 vector %0d", i), r, VEC[i][7:0]);
    end

    // R3 master line gating
    cyc(8'h08, 1'b0, 1'b0, 3'd0, 8'h00);
    check("R3 disabled", {7'd0, irq_master}, 8'h00);
    wr(3'd1, 8'h01);
    check("R3 enabled", {7'd0, irq_master}, 8'h01);
    wr(3'd0, 8'h08);
    check("R3 no status", {7'd0, irq_master}, 8'h00);

    // R4 / R6 / R9 configurable line 0 on channel 5
    cyc(8'h20, 1'b0, 1'b0, 3'd0, 8'h00);
    rd(3'd0, r); check("R2 ch5 pending", r, 8'h20);
    wr(3'd2, 8'h85);
    rd(3'd0, r); check("R4 held hidden", r, 8'h00);
    check("R4 master low", {7'd0, irq_master}, 8'h00);
    cyc(8'h20, 1'b0, 1'b0, 3'd0, 8'h00);
    rd(3'd5, r); check("R6 flag set", r, 8'h01);
    rd(3'd0, r); check("R4 done not in status", r, 8'h00);
    check("R6 line disabled", {5'd0, irq_cfg}, 8'h00);
    wr(3'd0, 8'h20);
    wr(3'd1, 8'h03);
    check("R6 line enabled", {5'd0, irq_cfg}, 8'h01);
    cyc(8'h20, 1'b0, 1'b1, 3'd5, 8'h01);
    rd(3'd5, r); check("R6 set wins", r, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, r); check("R6 cleared", r, 8'h00);
    check("R6 line low", {5'd0, irq_cfg}, 8'h00);
    wr(3'd2, 8'h05);
    rd(3'd2, r); check("R9 assign read", r, 8'h05);
    rd(3'd0, r); check("R4/R9 clear ignored, bit back", r, 8'h20);
    cyc(8'h20, 1'b0, 1'b0, 3'd0, 8'h00);
    rd(3'd5, r); check("R9 flag untouched", r, 8'h00);
    wr(3'd0, 8'h20);

    // R6 line 2 on channel 7
    wr(3'd4, 8'h87);
    cyc(8'h80, 1'b0, 1'b0, 3'd0, 8'h00);
    rd(3'd5, r); check("R6 line2 flag", r, 8'h04);
    rd(3'd0, r); check("R4 ch7 hidden", r, 8'h00);

    // R7 error line
    cyc(8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
    rd(3'd6, r); check("R7 err flag", r, 8'h01);
    check("R7 err disabled", {7'd0, irq_err}, 8'h00);
    wr(3'd1, 8'h10);
    check("R7 err enabled", {7'd0, irq_err}, 8'h01);
    wr(3'd6, 8'h01);
    check("R7 err cleared", {7'd0, irq_err}, 8'h00);

    // R8 software requests
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h42;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 sw_req pulse", sw_req, 8'h42);
    @(negedge clk);
    check("R8 sw_req ends", sw_req, 8'h00);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule